// File: doc/BRIEF.md
# Staged Output Update Controller

This block owns the output data of a forty-pin general-purpose port arranged as five banks of eight pins. A serial slave front end hands it register-write strobes, each carrying a bank index and a data byte. It also supplies one-cycle strobes that mark an acknowledge phase, a stop condition and a start condition. Written bytes first land in a staging register for their bank. They move into the committed output register only at the commit point that the mode bit selects: every acknowledge, or only the stop condition. With stop-commit, a burst that writes several adjacent banks changes all of them on the same clock edge.

A broadcast register can force any set of banks onto one common level without touching the committed registers. Only the pins show that level, so the committed registers read back through `obank_q` stop showing the pin state of the overridden banks. The drive enable of each pin needs two things: the direction bit marks the pin as an output, and the external output-enable pin is at its active level. A polarity bit chooses that active level. The pin values and enables are combinational from the stored state and the enable pin.

Top module: `out_stage_ctrl`

## Requirements
- R1: After reset, every committed output register, the broadcast register and both mode bits are 0. Mode bit 0 is commit-on-acknowledge and mode bit 1 is OE polarity. With OE low and every direction bit 0, every pin is enabled and drives 0.
- R2: With mode bit 0 clear, a written byte does not reach `obank_q` or the pins on an acknowledge. It appears on the clock edge that samples `stop_stb`.
- R3: With mode bit 0 set, a staged byte appears on the clock edge that samples `ack_stb`.
- R4: In stop-commit mode, several banks written during one transaction all change on the same edge, the one that samples `stop_stb`.
- R5: A start strobe discards staged data that has not been committed. A later stop then leaves every committed register unchanged.
- R6: Broadcast register bits 4..0 select banks 4..0 and bit 7 is the common level. Every pin of a selected bank drives bit 7. The pins of an unselected bank drive its committed register.
- R7: Writing the broadcast register leaves `obank_q` unchanged.
- R8: With polarity 0 the OE pin is active low, and with polarity 1 it is active high. While it is inactive, all 40 drive enables are 0.
- R9: A pin's drive enable is 1 only where its direction bit is 0 (output) and OE is active. A direction bit of 1 means input.
- R10: A write to bank index 5, 6 or 7 changes no register, even after a commit.
- R11: A write in the same cycle as a commit strobe is not committed by that strobe. It stays staged for the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Output-data write strobe |
| wr_bank | input | 3 | Bank index of the write (0..4 valid) |
| wr_data | input | 8 | Byte to stage |
| ack_stb | input | 1 | Acknowledge-phase strobe |
| stop_stb | input | 1 | Stop-condition strobe |
| start_stb | input | 1 | Start-condition strobe |
| bc_wr | input | 1 | Broadcast register write strobe |
| bc_wdata | input | 8 | Broadcast value: bits 4..0 bank selects, bit 7 level |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_wdata | input | 2 | Bit 0 commit-on-ack, bit 1 OE polarity |
| dir_in | input | 40 | Per-pin direction, 1 = input |
| oe_pin | input | 1 | External output-enable pin |
| obank_q | output | 40 | Committed output registers, bank 0 in bits 7..0 |
| pin_out | output | 40 | Pin drive values |
| pin_en | output | 40 | Pin drive enables |

## Verification
A staging or pending bit that is wrong shows up at a later commit. The wrong committed value appears on `obank_q` and the pins on the edge after the acknowledge or stop. If that transaction is never committed, the error stays hidden. A wrong commit decode shows up one edge early or late compared with the strobe that should have committed the data. Wrong broadcast or enable gating is visible at once on `pin_out` and `pin_en`, so every cycle compares all three buses against a model.

// File: rtl/out_stage_pkg.sv
package out_stage_pkg;
  localparam int NBANK  = 5;
  localparam int BANK_W = 8;
  localparam int PINS   = NBANK * BANK_W;
  localparam int BIDX_W = 3;

  typedef struct packed {
    logic oe_pol;
    logic ack_mode;
  } mode_t;
endpackage

// File: rtl/commit_ctrl.sv
module commit_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_stb,
  input  logic stop_stb,
  input  logic start_stb,
  input  logic ack_mode,
  output logic commit,
  output logic discard
);
  always_comb begin
    commit  = stop_stb | (ack_stb & ack_mode);
    discard = start_stb;
  end

  // R2: in stop mode an acknowledge alone never commits
  assert_ack_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && !ack_mode && !stop_stb) |-> !commit);
endmodule

// File: rtl/bank_stage.sv
module bank_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         commit,
  input  logic         discard,
  output logic [W-1:0] oreg_q
);
  logic [W-1:0] stage_q, stage_d, oreg_d;
  logic         pend_q, pend_d;

  always_comb begin
    stage_d = wr ? wdata : stage_q;
    oreg_d  = (commit && pend_q) ? stage_q : oreg_q;
    pend_d  = pend_q;
    if (commit || discard) pend_d = 1'b0;
    if (wr)                pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      oreg_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      oreg_q  <= oreg_d;
      pend_q  <= pend_d;
    end
  end

  // R2: committed data holds between commit strobes
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(oreg_q));
  // R5: a start with no write leaves nothing pending
  assert_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && !wr) |=> !pend_q);
  // R11: a write beside a commit stays pending
  assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && commit) |=> pend_q);
endmodule

// File: rtl/pin_mux.sv
module pin_mux #(
  parameter int NB = 5,
  parameter int W  = 8
) (
  input  logic [NB*W-1:0] oreg,
  input  logic [NB-1:0]   bsel,
  input  logic            bval,
  input  logic [NB*W-1:0] dir,
  input  logic            oe_act,
  output logic [NB*W-1:0] pout,
  output logic [NB*W-1:0] pen
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign pout[b*W +: W] = bsel[b] ? {W{bval}} : oreg[b*W +: W];
  end
  assign pen = ~dir & {NB*W{oe_act}};
endmodule

// File: rtl/out_stage_ctrl.sv
module out_stage_ctrl
  import out_stage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BIDX_W-1:0] wr_bank,
  input  logic [BANK_W-1:0] wr_data,
  input  logic              ack_stb,
  input  logic              stop_stb,
  input  logic              start_stb,
  input  logic              bc_wr,
  input  logic [BANK_W-1:0] bc_wdata,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_wdata,
  input  logic [PINS-1:0]   dir_in,
  input  logic              oe_pin,
  output logic [PINS-1:0]   obank_q,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_en
);
  mode_t             mode_q, mode_d;
  logic [BANK_W-1:0] bc_q, bc_d;
  logic              commit, discard, oe_act;

  always_comb begin
    mode_d = cfg_wr ? mode_t'(cfg_wdata) : mode_q;
    bc_d   = bc_wr ? bc_wdata : bc_q;
    oe_act = mode_q.oe_pol ? oe_pin : ~oe_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      bc_q   <= '0;
    end else begin
      mode_q <= mode_d;
      bc_q   <= bc_d;
    end
  end

  commit_ctrl u_commit (
    .clk(clk), .rst_n(rst_n), .ack_stb(ack_stb), .stop_stb(stop_stb),
    .start_stb(start_stb), .ack_mode(mode_q.ack_mode),
    .commit(commit), .discard(discard)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic wr_b;
    assign wr_b = wr_en && (wr_bank == BIDX_W'(b));
    bank_stage #(.W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(wr_b), .wdata(wr_data),
      .commit(commit), .discard(discard), .oreg_q(obank_q[b*BANK_W +: BANK_W])
    );

    // R6: unselected banks show their committed register on the pins
    assert_unsel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !bc_q[b] |-> pin_out[b*BANK_W +: BANK_W] == obank_q[b*BANK_W +: BANK_W]);
  end

  pin_mux #(.NB(NBANK), .W(BANK_W)) u_mux (
    .oreg(obank_q), .bsel(bc_q[NBANK-1:0]), .bval(bc_q[BANK_W-1]),
    .dir(dir_in), .oe_act(oe_act), .pout(pin_out), .pen(pin_en)
  );

  // R7: a broadcast write alone does not move the committed registers
  assert_bc_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_wr && !commit) |=> $stable(obank_q));
  // R9: input-configured pins are never driven
  assert_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en & dir_in) == '0);
  // R8: pin at its inactive level under the stored polarity disables all drive
  assert_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_pin != mode_q.oe_pol) |-> pin_en == '0);
endmodule

// File: tb/test_out_stage_ctrl.sv
module test_out_stage_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, ack_stb, stop_stb, start_stb, bc_wr, cfg_wr, oe_pin;
  logic [2:0]  wr_bank;
  logic [7:0]  wr_data, bc_wdata;
  logic [1:0]  cfg_wdata;
  logic [39:0] dir_in, obank_q, pin_out, pin_en;

  logic [7:0] m_stage [5];
  logic [7:0] m_oreg  [5];
  logic [4:0] m_pend;
  logic [7:0] m_bc;
  logic [1:0] m_cfg;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  out_stage_ctrl i_out_stage_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_data(wr_data),
    .ack_stb(ack_stb), .stop_stb(stop_stb), .start_stb(start_stb),
    .bc_wr(bc_wr), .bc_wdata(bc_wdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .dir_in(dir_in), .oe_pin(oe_pin), .obank_q(obank_q), .pin_out(pin_out), .pin_en(pin_en)
  );

  function automatic logic [39:0] exp_oreg();
    logic [39:0] v;
    for (int b = 0; b < 5; b++) v[b*8 +: 8] = m_oreg[b];
    return v;
  endfunction

  function automatic logic [39:0] exp_pins();
    logic [39:0] v;
    for (int b = 0; b < 5; b++) v[b*8 +: 8] = m_bc[b] ? {8{m_bc[7]}} : m_oreg[b];
    return v;
  endfunction

  function automatic logic [39:0] exp_en();
    logic act;
    act = m_cfg[1] ? oe_pin : ~oe_pin;
    return ~dir_in & {40{act}};
  endfunction

  task automatic check(string tag);
    checks++;
    if (obank_q !== exp_oreg() || pin_out !== exp_pins() || pin_en !== exp_en()) begin
      errors++;
      $display("FAIL %s: oreg=%h pins=%h en=%h expected oreg=%h pins=%h en=%h",
               tag, obank_q, pin_out, pin_en, exp_oreg(), exp_pins(), exp_en());
    end
  endtask

  task automatic model_edge();
    logic commit;
    commit = stop_stb | (ack_stb & m_cfg[0]);
    for (int b = 0; b < 5; b++)
      if (commit && m_pend[b]) m_oreg[b] = m_stage[b];
    if (commit || start_stb) m_pend = '0;
    if (wr_en && wr_bank < 3'd5) begin
      m_stage[wr_bank] = wr_data;
      m_pend[wr_bank]  = 1'b1;
    end
    if (bc_wr)  m_bc  = bc_wdata;
    if (cfg_wr) m_cfg = cfg_wdata;
  endtask

  task automatic idle_inputs();
    wr_en = 0; ack_stb = 0; stop_stb = 0; start_stb = 0; bc_wr = 0; cfg_wr = 0;
  endtask

  // Inputs are set at a falling edge; result checked at the next falling edge.
  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    idle_inputs();
    check(tag);
  endtask

  task automatic wr(input logic [2:0] b, input logic [7:0] d, input logic ak, string tag);
    wr_en = 1; wr_bank = b; wr_data = d; ack_stb = ak; cyc(tag);
  endtask
  task automatic ack(string tag);   ack_stb = 1;   cyc(tag); endtask
  task automatic stop(string tag);  stop_stb = 1;  cyc(tag); endtask
  task automatic start(string tag); start_stb = 1; cyc(tag); endtask
  task automatic cfg(input logic [1:0] v, string tag); cfg_wr = 1; cfg_wdata = v; cyc(tag); endtask
  task automatic bc(input logic [7:0] v, string tag);  bc_wr = 1; bc_wdata = v; cyc(tag); endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 13;
    void'($urandom(seed));
    idle_inputs();
    wr_bank = 0; wr_data = 0; bc_wdata = 0; cfg_wdata = 0; dir_in = '0; oe_pin = 0;
    for (int b = 0; b < 5; b++) begin m_stage[b] = 0; m_oreg[b] = 0; end
    m_pend = 0; m_bc = 0; m_cfg = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after release");

    // stop-commit mode
    wr(3'd0, 8'hA5, 1'b0, "R2 write staged");
    ack("R2 ack ignored");
    stop("R2 stop commits");
    wr(3'd1, 8'h11, 1'b1, "R4 bank1 staged");
    wr(3'd2, 8'h22, 1'b1, "R4 bank2 staged");
    wr(3'd3, 8'h33, 1'b1, "R4 bank3 staged");
    stop("R4 banks commit together");
    wr(3'd1, 8'hFF, 1'b0, "R5 staged");
    start("R5 start discards");
    stop("R5 stop commits nothing");
    wr(3'd5, 8'h77, 1'b0, "R10 bank5");
    wr(3'd7, 8'h99, 1'b0, "R10 bank7");
    stop("R10 nothing changed");

    // ack-commit mode
    cfg(2'b01, "R3 mode set");
    wr(3'd4, 8'h3C, 1'b0, "R3 staged");
    ack("R3 ack commits");
    wr(3'd0, 8'h5A, 1'b1, "R11 write with ack stays staged");
    ack("R11 next ack commits");

    // broadcast and enables
    bc(8'h85, "R6 R7 broadcast ones on banks 0 and 2");
    bc(8'h1A, "R6 R7 broadcast zeros on banks 1,3,4");
    bc(8'h00, "R6 broadcast off");
    oe_pin = 1; @(negedge clk); check("R8 pol0 pin high disables");
    cfg(2'b10, "R8 pol1 pin high enables");
    oe_pin = 0; @(negedge clk); check("R8 pol1 pin low disables");
    oe_pin = 1; dir_in = 40'hF0_0F_AA_55_C3; @(negedge clk); check("R9 direction mask");

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 99);
      dir_in = {$urandom(), $urandom()} ;
      oe_pin = 1'($urandom_range(0, 1));
      if (op < 45) begin
        wr_en = 1; wr_bank = 3'($urandom_range(0, 5)); wr_data = 8'($urandom());
        ack_stb = ($urandom_range(0, 3) == 0);
        stop_stb = ($urandom_range(0, 9) == 0);
      end else if (op < 65) ack_stb = 1;
      else if (op < 80) stop_stb = 1;
      else if (op < 86) start_stb = 1;
      else if (op < 94) begin bc_wr = 1; bc_wdata = 8'($urandom()); end
      else begin cfg_wr = 1; cfg_wdata = 2'($urandom()); end
      cyc("R2 R3 R6 R8 random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule